// File: doc/BRIEF.md
# Tick-Count Watchdog Timer with Sticky Timeout Flag

This block is a programmable watchdog that sits behind a 32-bit timeout register. Software writes a count of base-clock ticks. Any nonzero write arms the watchdog and restarts the count, so repeated writes keep it fed. A write of zero disarms it. If the programmed number of ticks passes with no new write, the block raises a board-wide reset request for a fixed number of system clocks. It also latches a sticky timeout flag and drives an active-low status pin. The reset request does not clear the flag or the status pin. Only a software clear or a true power-on reset clears them.

Three states drive the control. IDLE means disarmed. ARMED means counting ticks. FIRE means the reset pulse is being driven. The transitions are named as follows:

- ARM (IDLE to ARMED) occurs on a nonzero write.
- FEED (ARMED to ARMED) occurs on a nonzero write while armed and reloads the count.
- DISARM (ARMED to IDLE) occurs on a zero write.
- EXPIRE (ARMED to FIRE) occurs on the tick that reaches the end of the count.
- RELEASE (FIRE to IDLE) occurs when the pulse has run its full length.

The block disarms itself after firing.

Top module: `wdog_tick_guard`

## Requirements
- R1: After power-on reset, `board_rst_req` is 0, `wdg_flag` is 0, `wdt_status_n` is 1, `tmo_rd_data` is 0, and the watchdog is disarmed.
- R2: `tmo_rd_data` returns the value of the last accepted write to the timeout register.
- R3: A nonzero write of N arms the watchdog. A tick in the write cycle is not counted. The reset request rises at the clock edge that samples the N-th later tick, and not before.
- R4: A nonzero write while armed reloads the count to the new value (feed). A tick in the same cycle as the write is ignored.
- R5: A write of zero disarms the watchdog. No number of ticks then causes a reset request.
- R6: `board_rst_req` stays high for exactly PULSE_CYCLES consecutive clocks (16 by default).
- R7: After firing, the watchdog is disarmed and `tmo_rd_data` reads 0. Writes to the timeout register while the pulse is high are ignored.
- R8: `wdg_flag` is set at the same edge at which the reset request rises. It stays set after the pulse ends.
- R9: `wdt_status_n` is 0 while `wdg_flag` is set and 1 otherwise. It goes high again when the flag is cleared.
- R10: A flag write (`flag_wr_en`=1) with `flag_wr_b31`=1 clears `wdg_flag`. A flag write with `flag_wr_b31`=0 leaves it unchanged. Power-on reset also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | One-cycle strobe at the base sample clock rate |
| tmo_wr_en | input | 1 | Write strobe for the timeout register |
| tmo_wr_data | input | 32 | Timeout value in ticks; 0 disarms |
| tmo_rd_data | output | 32 | Readback of the timeout register |
| flag_wr_en | input | 1 | Write strobe for the interrupt status register |
| flag_wr_b31 | input | 1 | Bit 31 of that write; 1 clears the flag |
| board_rst_req | output | 1 | Board-wide reset request pulse |
| wdg_flag | output | 1 | Sticky timeout flag |
| wdt_status_n | output | 1 | Active-low watchdog status pin |

## Verification
A table of timeout values and tick counts drives the main function. One tick short of the timeout must not fire, and exactly the timeout must fire, for timeouts of 1, 3 and 8. These cases separate an off-by-one in the count from a correct terminal test. A zero entry placed after a partly counted value shows that disarming differs from an immediate timeout. Directed sequences then try the following:

- a feed just before expiry, with a coincident tick;
- writes made during the pulse;
- flag writes with bit 31 clear and set;
- a power-on reset with the flag set.

Together they separate reload, ignore and sticky-clear behaviour from one another.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_ctrl_fsm.sv
module wdog_ctrl_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      tick,
    input  logic      wr_en,
    input  logic      wr_nonzero,
    input  logic      expire,
    input  logic      pulse_done,
    output wd_state_e state_o,
    output logic      accept_wr,
    output logic      load,
    output logic      dec,
    output logic      clear,
    output logic      fire_entry,
    output logic      rst_req
);
    wd_state_e state_q, state_d;

    always_comb begin
        accept_wr  = wr_en && (state_q != WD_FIRE);
        load       = accept_wr && wr_nonzero;
        dec        = tick && (state_q == WD_ARMED) && !accept_wr;
        fire_entry = (state_q == WD_ARMED) && !accept_wr && expire;
        clear      = (accept_wr && !wr_nonzero) || fire_entry;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  if (load) state_d = WD_ARMED;
            WD_ARMED: begin
                if (accept_wr)   state_d = wr_nonzero ? WD_ARMED : WD_IDLE;
                else if (expire) state_d = WD_FIRE;
            end
            WD_FIRE:  if (pulse_done) state_d = WD_IDLE;
            default:  state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o = state_q;
        rst_req = (state_q == WD_FIRE);
    end

    // R6: the pulse always hands back to IDLE when its timer finishes
    a_r6_release_to_idle: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == WD_FIRE && pulse_done) |=> (state_q == WD_IDLE));
    // R7: a timeout write has no effect while the pulse is high
    a_r7_fire_ignores_write: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == WD_FIRE && wr_en) |-> !load);
endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    input  logic             dec,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (clear) cnt_q <= '0;
        else if (dec)   cnt_q <= cnt_q - 1'b1;
    end

    assign expire = dec && (cnt_q == CNT_W'(1));

    // R3: the count is never decremented from zero while armed
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!por_n)
        dec |-> (cnt_q != '0));
endmodule

// File: rtl/wdog_pulse_timer.sv
module wdog_pulse_timer #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int PW_W = $clog2(PULSE_CYCLES + 1);
    logic [PW_W-1:0] pcnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                    pcnt_q <= '0;
        else if (start)                pcnt_q <= PW_W'(PULSE_CYCLES - 1);
        else if (run && pcnt_q != '0)  pcnt_q <= pcnt_q - 1'b1;
    end

    assign done = run && (pcnt_q == '0);

    // R6: a new pulse never starts while one is running
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!por_n)
        start |-> !run);
endmodule

// File: rtl/wdog_sticky_flag.sv
module wdog_sticky_flag (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R10: the flag only falls after an explicit clear request
    a_r10_clear_only: assert property (@(posedge clk) disable iff (!por_n)
        $fell(flag) |-> $past(clr));
endmodule

// File: rtl/wdog_tick_guard.sv
module wdog_tick_guard #(
    parameter int CNT_W        = 32,
    parameter int PULSE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             tmo_wr_en,
    input  logic [CNT_W-1:0] tmo_wr_data,
    output logic [CNT_W-1:0] tmo_rd_data,
    input  logic             flag_wr_en,
    input  logic             flag_wr_b31,
    output logic             board_rst_req,
    output logic             wdg_flag,
    output logic             wdt_status_n
);
    import wdog_pkg::*;

    wd_state_e state;
    logic accept_wr, load, dec, clear, fire_entry, expire, pulse_done;
    logic [CNT_W-1:0] tmo_q;

    wdog_ctrl_fsm u_fsm (
        .clk(clk), .por_n(por_n), .tick(tick), .wr_en(tmo_wr_en),
        .wr_nonzero(|tmo_wr_data), .expire(expire), .pulse_done(pulse_done),
        .state_o(state), .accept_wr(accept_wr), .load(load), .dec(dec),
        .clear(clear), .fire_entry(fire_entry), .rst_req(board_rst_req)
    );

    wdog_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .por_n(por_n), .load(load), .load_val(tmo_wr_data),
        .clear(clear), .dec(dec), .expire(expire)
    );

    wdog_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk(clk), .por_n(por_n), .start(fire_entry),
        .run(state == WD_FIRE), .done(pulse_done)
    );

    wdog_sticky_flag u_flag (
        .clk(clk), .por_n(por_n), .set(fire_entry),
        .clr(flag_wr_en && flag_wr_b31), .flag(wdg_flag)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          tmo_q <= '0;
        else if (fire_entry) tmo_q <= '0;
        else if (accept_wr)  tmo_q <= tmo_wr_data;
    end

    assign tmo_rd_data  = tmo_q;
    assign wdt_status_n = ~wdg_flag;

    // R8: the flag is set whenever the reset request rises
    a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (!por_n)
        $rose(board_rst_req) |-> wdg_flag);
    // R9: the status pin is low during the pulse
    a_r9_status_low_in_pulse: assert property (@(posedge clk) disable iff (!por_n)
        board_rst_req |-> !wdt_status_n);
    // R7: the register reads zero once the pulse ends
    a_r7_cleared_after_fire: assert property (@(posedge clk) disable iff (!por_n)
        $fell(board_rst_req) |-> (tmo_rd_data == '0));
endmodule

// File: tb/wdog_tick_guard_tb.sv
module wdog_tick_guard_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        tick = 1'b0;
    logic        tmo_wr_en = 1'b0;
    logic [31:0] tmo_wr_data = '0;
    logic [31:0] tmo_rd_data;
    logic        flag_wr_en = 1'b0;
    logic        flag_wr_b31 = 1'b0;
    logic        board_rst_req, wdg_flag, wdt_status_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wdog_tick_guard dut_i (
        .clk(clk), .por_n(por_n), .tick(tick), .tmo_wr_en(tmo_wr_en),
        .tmo_wr_data(tmo_wr_data), .tmo_rd_data(tmo_rd_data),
        .flag_wr_en(flag_wr_en), .flag_wr_b31(flag_wr_b31),
        .board_rst_req(board_rst_req), .wdg_flag(wdg_flag),
        .wdt_status_n(wdt_status_n)
    );

    localparam int NVEC = 6;
    localparam logic [31:0] V_TMO   [NVEC] = '{32'd3, 32'd3, 32'd1, 32'd5, 32'd0, 32'd8};
    localparam int          V_TICKS [NVEC] = '{2, 3, 1, 4, 6, 8};
    localparam logic        V_FIRE  [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_tmo(input logic [31:0] v, input logic with_tick);
        @(negedge clk);
        tmo_wr_en = 1'b1; tmo_wr_data = v; tick = with_tick;
        @(negedge clk);
        tmo_wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (i != n - 1) @(negedge clk);
        end
    endtask

    task automatic flag_write(input logic b31);
        @(negedge clk);
        flag_wr_en = 1'b1; flag_wr_b31 = b31;
        @(negedge clk);
        flag_wr_en = 1'b0; flag_wr_b31 = 1'b0;
    endtask

    task automatic measure_pulse(output int n);
        n = 0;
        while (board_rst_req && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: run did not end");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int plen;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(board_rst_req == 0, "R1 rst_req", board_rst_req, 0);
        check(wdg_flag == 0, "R1 flag", wdg_flag, 0);
        check(wdt_status_n == 1, "R1 status_n", wdt_status_n, 1);
        check(tmo_rd_data == 0, "R1 readback", tmo_rd_data, 0);
        give_ticks(5);
        check(board_rst_req == 0, "R1 disarmed at reset", board_rst_req, 0);

        // Vector table: timeout N, ticks applied, fire expected (R3, R5, R2)
        for (int v = 0; v < NVEC; v++) begin
            write_tmo(V_TMO[v], 1'b0);
            check(tmo_rd_data == V_TMO[v], "R2 readback", tmo_rd_data, V_TMO[v]);
            if (V_TICKS[v] > 1) begin
                give_ticks(V_TICKS[v] - 1);
                check(board_rst_req == 0, "R3 early", board_rst_req, 0);
            end
            give_ticks(1);
            check(board_rst_req == V_FIRE[v], (V_TMO[v] == 0) ? "R5 zero disarms" : "R3 fire tick",
                  board_rst_req, V_FIRE[v]);
            if (V_FIRE[v]) begin
                check(wdg_flag == 1, "R8 flag on fire", wdg_flag, 1);
                measure_pulse(plen);
                check(plen == 16, "R6 pulse width", plen, 16);
                flag_write(1'b1);
            end
        end

        // R4 feed: write 5, 4 ticks, write 5 with coincident tick, 4 ticks, then 1 more
        write_tmo(32'd5, 1'b0);
        give_ticks(4);
        write_tmo(32'd5, 1'b1);
        give_ticks(4);
        check(board_rst_req == 0, "R4 feed reloads", board_rst_req, 0);
        give_ticks(1);
        check(board_rst_req == 1, "R4 fire after feed", board_rst_req, 1);
        // R7 write during pulse ignored
        write_tmo(32'd9, 1'b0);
        measure_pulse(plen);
        check(tmo_rd_data == 0, "R7 readback zero after fire", tmo_rd_data, 0);
        // R8/R9 flag survives the pulse
        check(wdg_flag == 1, "R8 flag sticky", wdg_flag, 1);
        check(wdt_status_n == 0, "R9 status low", wdt_status_n, 0);
        give_ticks(12);
        check(board_rst_req == 0, "R7 disarmed after fire", board_rst_req, 0);
        // R10 write with bit 31 clear leaves the flag
        flag_write(1'b0);
        check(wdg_flag == 1, "R10 b31=0 no effect", wdg_flag, 1);
        flag_write(1'b1);
        check(wdg_flag == 0, "R10 b31=1 clears", wdg_flag, 0);
        check(wdt_status_n == 1, "R9 status high after clear", wdt_status_n, 1);

        // R5 disarm mid-count
        write_tmo(32'd4, 1'b0);
        give_ticks(2);
        write_tmo(32'd0, 1'b0);
        check(tmo_rd_data == 0, "R2 readback zero", tmo_rd_data, 0);
        give_ticks(8);
        check(board_rst_req == 0, "R5 disarm mid-count", board_rst_req, 0);

        // R10 power-on reset clears the flag
        write_tmo(32'd2, 1'b0);
        give_ticks(2);
        check(wdg_flag == 1, "R8 flag set", wdg_flag, 1);
        measure_pulse(plen);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        check(wdg_flag == 0, "R10 por clears flag", wdg_flag, 0);
        check(wdt_status_n == 1, "R9 status after por", wdt_status_n, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule